// File: doc/BRIEF.md
# Read-Cycled Identification Register

This block is a single read location on a simple asynchronous host register bus, with an active-low chip select, read strobe and write strobe. Reading it once does not return the whole build identity. Successive reads step through a fixed sequence of four 16-bit words, and the sequence then wraps. The words are a core identifier, the build year, the build month and day, and a build revision. Each word is returned zero-extended to 32 bits. Software reads the location four times and reassembles the fields.

The bus strobes are asynchronous to the block clock, so they pass through a synchronizer. A read is recognised when chip select and the read strobe are both active, the write strobe is idle, and the address matches the base offset. The data word is presented while the strobe is held. The sequence index advances once, when the strobe is released, so a host that holds the strobe for a long time still gets consecutive words. Bits 15:14 of every word carry the current index, which lets software find its place in the cycle. All identity values are module parameters.

Top module: `idseq_reg`

## Requirements
- R1: Successive reads of the base address return the words for index 0, 1, 2 and 3 in that order, and the fifth read returns the index-0 word again.
- R2: The index-1 word carries (build year − 2000) in bits 12:8. Its bits 13 and 7:0 read zero.
- R3: The index-2 word carries the build month in bits 11:8 and the build day in bits 4:0. Its bits 13:12 and 7:5 read zero.
- R4: The index-0 word carries the 14-bit core identifier in bits 13:0. The index-3 word carries the 8-bit build revision in bits 7:0, with bits 13:8 zero.
- R5: Bits 31:16 of the read data are always zero.
- R6: Bits 15:14 of every returned word hold that word's sequence index (0 to 3).
- R7: The index advances exactly once per read transaction, after the read strobe is released. Holding the strobe for many cycles returns the same word throughout and skips nothing.
- R8: Reset (asynchronous assertion, synchronous release) sets the index to 0 and the read data to zero, so the first read after reset returns the index-0 word.
- R9: A write transaction (chip select and write strobe active) to the base address returns no data and does not change the index.
- R10: A read at any address other than the base offset, or a read strobe while chip select is inactive, returns zero and does not change the index.
- R11: Read data is nonzero only while a matching read is in progress, and returns to zero after the strobe is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| bus_cs_n | input | 1 | Host chip select, active low, asynchronous |
| bus_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| bus_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| bus_addr | input | ADDR_W | Host word address |
| bus_rdata | output | 32 | Read data, upper 16 bits zero |

## Verification
The bench builds the block with a 4-bit address and base offset 0, so that every address of the space can be swept for decode. It uses a year of 2031, month 11, day 12, a nonzero core identifier and a nonzero revision. Every field is therefore nonzero and its exact bit position is visible. The bench runs several full wraps of the four-word cycle under short and very long strobes, with writes, off-address reads and deselected strobes placed in between. It also resets in the middle of the sequence, so the index is tested from every starting value.

// File: rtl/idseq_pkg.sv
package idseq_pkg;

  localparam int SEQ_LEN   = 4;
  localparam int IDX_W     = $clog2(SEQ_LEN);
  localparam int WORD_W    = 16;
  localparam int BUS_W     = 32;
  localparam int YEAR_BASE = 2000;

  typedef logic [IDX_W-1:0] seq_idx_t;

  typedef enum logic [IDX_W-1:0] {
    SLOT_CORE = 2'd0,
    SLOT_YEAR = 2'd1,
    SLOT_DATE = 2'd2,
    SLOT_REV  = 2'd3
  } slot_e;

  typedef struct packed {
    logic [13:0] core_id;
    logic [4:0]  year_off;
    logic [3:0]  month;
    logic [4:0]  day;
    logic [7:0]  rev;
  } ident_t;

  function automatic logic [WORD_W-1:0] pack_word(seq_idx_t i, ident_t f);
    logic [WORD_W-1:0] w;
    w = '0;
    w[15:14] = i;
    case (slot_e'(i))
      SLOT_CORE: w[13:0] = f.core_id;
      SLOT_YEAR: w[12:8] = f.year_off;
      SLOT_DATE: begin
        w[11:8] = f.month;
        w[4:0]  = f.day;
      end
      default:   w[7:0]  = f.rev;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/idseq_rst_sync.sv
module idseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/idseq_bus_sync.sv
module idseq_bus_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = async_i;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/idseq_rd_track.sv
module idseq_rd_track (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  input  logic rd_n_s,
  input  logic wr_n_s,
  input  logic addr_hit,
  output logic rd_act,
  output logic rd_strobe,
  output logic adv
);
  logic hit_q;
  logic hit_d;
  logic hit_en;

  always_comb begin
    rd_strobe = !cs_n_s && !rd_n_s;
    rd_act    = rd_strobe && wr_n_s && addr_hit;
    adv       = hit_q && !rd_strobe;
    hit_en    = adv || rd_act;
    hit_d     = adv ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hit_q <= 1'b0;
    else if (hit_en) hit_q <= hit_d;
  end
endmodule

// File: rtl/idseq_index.sv
module idseq_index
  import idseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv,
  output seq_idx_t idx
);
  seq_idx_t idx_q;
  seq_idx_t idx_d;

  always_comb begin
    idx_d = (idx_q == seq_idx_t'(SEQ_LEN - 1)) ? '0 : idx_q + seq_idx_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= '0;
    else if (adv) idx_q <= idx_d;
  end

  assign idx = idx_q;
endmodule

// File: rtl/idseq_reg.sv
module idseq_reg
  import idseq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BASE_ADDR   = 0,
  parameter int SYNC_STAGES = 2,
  parameter int CORE_ID     = 14'h0A51,
  parameter int BUILD_YEAR  = 2024,
  parameter int BUILD_MONTH = 6,
  parameter int BUILD_DAY   = 15,
  parameter int BUILD_REV   = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [BUS_W-1:0]  bus_rdata
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
  localparam ident_t FIELDS = '{
    core_id:  14'(CORE_ID),
    year_off: 5'(BUILD_YEAR - YEAR_BASE),
    month:    4'(BUILD_MONTH),
    day:      5'(BUILD_DAY),
    rev:      8'(BUILD_REV)
  };

  logic       rst_n_int;
  logic [2:0] strobes_s;
  logic       addr_hit;
  logic       rd_act;
  logic       rd_strobe;
  logic       adv;
  seq_idx_t   idx;
  logic [BUS_W-1:0] rdata_d;
  logic [BUS_W-1:0] rdata_q;

  idseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  idseq_bus_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .async_i ({bus_cs_n, bus_rd_n, bus_wr_n}),
    .sync_o  (strobes_s)
  );

  assign addr_hit = (bus_addr == BASE);

  idseq_rd_track u_track (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cs_n_s    (strobes_s[2]),
    .rd_n_s    (strobes_s[1]),
    .wr_n_s    (strobes_s[0]),
    .addr_hit  (addr_hit),
    .rd_act    (rd_act),
    .rd_strobe (rd_strobe),
    .adv       (adv)
  );

  idseq_index u_idx (
    .clk   (clk),
    .rst_n (rst_n_int),
    .adv   (adv),
    .idx   (idx)
  );

  always_comb begin
    rdata_d = '0;
    if (rd_act) rdata_d[WORD_W-1:0] = pack_word(idx, FIELDS);
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) rdata_q <= '0;
    else            rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/idseq_reg_chk.sv
module idseq_reg_chk
  import idseq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rd_strobe,
  input logic             adv,
  input seq_idx_t         idx,
  input logic [BUS_W-1:0] rdata
);
  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[31:16] == 16'h0);

  // R1
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> idx == seq_idx_t'($past(idx) + 2'd1));

  // R9
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(idx));

  // R7
  adv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> !rd_strobe);

  // R6
  tag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata != '0) |-> rdata[15:14] == idx);
endmodule

bind idseq_reg idseq_reg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .rd_strobe (rd_strobe),
  .adv       (adv),
  .idx       (idx),
  .rdata     (bus_rdata)
);

// File: tb/idseq_reg_test.sv
module idseq_reg_test;
  localparam int AW    = 4;
  localparam int CID   = 14'h11A5;
  localparam int YEAR  = 2031;
  localparam int MONTH = 11;
  localparam int DAY   = 12;
  localparam int REV   = 8'h3C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          rd_n = 1'b1;
  logic          wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [31:0]   rdata;

  int checks = 0;
  int fails  = 0;
  int exp_idx = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  idseq_reg #(
    .ADDR_W(AW), .BASE_ADDR(0), .SYNC_STAGES(2), .CORE_ID(CID),
    .BUILD_YEAR(YEAR), .BUILD_MONTH(MONTH), .BUILD_DAY(DAY), .BUILD_REV(REV)
  ) uut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_rd_n(rd_n),
    .bus_wr_n(wr_n), .bus_addr(addr), .bus_rdata(rdata)
  );

  function automatic logic [31:0] exp_word(int i);
    logic [31:0] w;
    w = 32'(i) << 14;
    case (i)
      0: w = w | 32'(CID);
      1: w = w | (32'(YEAR - 2000) << 8);
      2: w = w | (32'(MONTH) << 8) | 32'(DAY);
      default: w = w | 32'(REV);
    endcase
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // read at address a, hold strobe for hold cycles; returns data sampled at end
  task automatic bus_read(logic [AW-1:0] a, int hold, bit sel, output logic [31:0] d);
    @(negedge clk);
    addr = a; cs_n = !sel; rd_n = 1'b0;
    idle(hold);
    d = rdata;
    cs_n = 1'b1; rd_n = 1'b1;
    idle(6);
  endtask

  task automatic bus_write(logic [AW-1:0] a);
    @(negedge clk);
    addr = a; cs_n = 1'b0; wr_n = 1'b0;
    idle(8);
    check("R9 write returns no data", rdata, 32'h0);
    cs_n = 1'b1; wr_n = 1'b1;
    idle(6);
  endtask

  task automatic read_expect(string req, int hold);
    logic [31:0] d;
    bus_read('0, hold, 1'b1, d);
    check(req, d, exp_word(exp_idx));
    check("R11 data cleared after release", rdata, 32'h0);
    exp_idx = (exp_idx + 1) % 4;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(5);
    // R8 reset state
    check("R8 reset data zero", rdata, 32'h0);

    // R1 R2 R3 R4 R5 R6: several full wraps with short strobes
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 4; k++) read_expect("R1/R2/R3/R4/R5/R6 sequence word", 6);

    // R7 long strobe: sample at several points while held
    begin
      logic [31:0] d;
      @(negedge clk);
      addr = '0; cs_n = 1'b0; rd_n = 1'b0;
      for (int t = 0; t < 10; t++) begin
        idle(20);
        check("R7 stable during long strobe", rdata, exp_word(exp_idx));
      end
      cs_n = 1'b1; rd_n = 1'b1;
      idle(6);
      exp_idx = (exp_idx + 1) % 4;
      bus_read('0, 6, 1'b1, d);
      check("R7 single advance after long strobe", d, exp_word(exp_idx));
      exp_idx = (exp_idx + 1) % 4;
    end

    // R10 sweep all other addresses
    for (int a = 1; a < (1 << AW); a++) begin
      logic [31:0] d;
      bus_read(AW'(a), 6, 1'b1, d);
      check("R10 off-address read zero", d, 32'h0);
    end
    read_expect("R10 index unchanged after off-address reads", 6);

    // R10 deselected strobe
    for (int k = 0; k < 3; k++) begin
      logic [31:0] d;
      bus_read('0, 6, 1'b0, d);
      check("R10 deselected read zero", d, 32'h0);
    end
    read_expect("R10 index unchanged after deselected reads", 6);

    // R9 writes at base
    for (int k = 0; k < 3; k++) bus_write('0);
    read_expect("R9 index unchanged after writes", 6);

    // R8 reset from every index
    for (int s = 0; s < 4; s++) begin
      while (exp_idx != s) read_expect("R1 advance to start point", 6);
      rst_n = 1'b0;
      idle(2);
      check("R8 data zero in reset", rdata, 32'h0);
      rst_n = 1'b1;
      idle(5);
      exp_idx = 0;
      read_expect("R8 first read after reset is word 0", 6);
    end

    // mixed hold lengths, two more wraps
    for (int k = 0; k < 8; k++) read_expect("R7 varied strobe lengths", 5 + 7 * k);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule